// File: doc/BRIEF.md
# Macroblock Intra Prediction Generator

This block builds the whole-block intra prediction for one macroblock from reconstructed pixels around it. It reads the row directly above the block, the column directly to its left and the corner pixel above-left. From these it produces an N x N prediction in one of four ways: a vertical copy, a horizontal copy, a flat average (DC), or a gradient with saturation (TrueMotion). Two flags tell the DC mode which neighbour sides exist. When neither side exists, DC falls back to mid-grey.

A parameter sets the block edge `N`. A luma block uses N = 16 with one plane. A chroma block uses N = 8 with two planes. In the two-plane form, one mode code and one pair of availability flags apply to both planes. Each plane has its own neighbour pixels, and the two planes are computed side by side. A single start strobe captures every input. The block then spends one setup cycle and streams the prediction one row per clock, tagged with a row index and a valid flag. A done pulse marks the last row.

Top module: `intra_pred_gen`

## Requirements
- R1: Mode code 1 (vertical): each output row equals the captured above row. Pixel c of a plane's row sits at bits [(p*N+c)*8 +: 8] of the pixel bus, where p is the plane index.
- R2: Mode code 2 (horizontal): every pixel of output row r equals captured left pixel r of the same plane.
- R3: Mode code 3 (TrueMotion): pixel (r,c) equals left[r] + above[c] - corner. The result is saturated to 0 when it is negative and to 255 when it exceeds 255.
- R4: Mode code 0 (DC) with both sides available: every pixel equals (sum of the N above and N left pixels + N) >> log2(2N).
- R5: Mode code 0 with exactly one side available: every pixel equals (sum of that side's N pixels + N/2) >> log2(N). The missing side is not used.
- R6: Mode code 0 with neither side available: every pixel equals 128.
- R7: In the two-plane form, each plane is predicted from its own above row, left column and corner pixel. The mode and the availability flags are shared by both planes.
- R8: A start with a mode code of 4 to 7 is dropped. No valid row and no done pulse follow it.
- R9: The start is captured at a clock edge. The next edge is a setup cycle with valid low. Rows 0 to N-1 then come out on N consecutive cycles with valid high and the row index counting up.
- R10: The done output is high exactly while row N-1 is presented. Valid is low on the cycle after that row.
- R11: A start raised while a block is in progress has no effect on the mode or the pixels of that block.
- R12: The neighbour pixels, the mode and the flags are held from the accepted start. Later changes on those inputs do not alter the block in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a block. Inputs are captured on the same edge |
| mode_i | input | 3 | 0 DC, 1 vertical, 2 horizontal, 3 TrueMotion. Other codes are dropped |
| up_avail_i | input | 1 | Above row exists |
| left_avail_i | input | 1 | Left column exists |
| above_i | input | PLANES*N*8 | Above rows. Plane p, pixel c at [(p*N+c)*8 +: 8] |
| corner_i | input | PLANES*8 | Above-left pixel per plane |
| left_i | input | PLANES*N*8 | Left columns. Plane p, pixel r at [(p*N+r)*8 +: 8] |
| pix_o | output | PLANES*N*8 | Predicted row, same packing as above_i. Zero when not valid |
| row_o | output | log2(N) | Index of the row on pix_o |
| valid_o | output | 1 | A prediction row is present |
| done_o | output | 1 | High with the last row of the block |

## Verification
The start edge captures the inputs, and the following edge is setup only. Row r is therefore due after the (r+2)-th edge counted from the start edge, done comes with row N-1, and valid drops one edge later. The bench drives inputs on falling edges and steps exactly one falling edge per expected state. At each step it compares valid, row index, done and both planes' rows against values it computes arithmetically from the pixels it has stored. Right after capture, the bench scrambles every neighbour input and raises a conflicting start. Rows that follow that point must still match the captured data.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

    typedef enum logic [2:0] {
        IPG_DC   = 3'd0,
        IPG_VERT = 3'd1,
        IPG_HORZ = 3'd2,
        IPG_TM   = 3'd3
    } ipg_mode_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_RUN   = 2'd2
    } ipg_phase_e;

endpackage

// File: rtl/ipg_dc_unit.sv
module ipg_dc_unit #(
    parameter int N = 16
) (
    input  logic [N*8-1:0] above_i,
    input  logic [N*8-1:0] left_i,
    input  logic           up_i,
    input  logic           lf_i,
    output logic [7:0]     dc_o
);
    // sum register wide enough for 2N * 255
    localparam int SW = $clog2(2 * N * 255 + 1);
    localparam int LN = $clog2(N);

    logic [SW-1:0] sum_a;
    logic [SW-1:0] sum_l;
    logic [SW-1:0] avg;

    always_comb begin
        sum_a = '0;
        sum_l = '0;
        for (int c = 0; c < N; c++) begin
            sum_a = sum_a + SW'(above_i[c*8 +: 8]);
            sum_l = sum_l + SW'(left_i[c*8 +: 8]);
        end
        if (up_i && lf_i) begin
            avg = (sum_a + sum_l + SW'(N)) >> (LN + 1);
        end else if (up_i) begin
            avg = (sum_a + SW'(N / 2)) >> LN;
        end else if (lf_i) begin
            avg = (sum_l + SW'(N / 2)) >> LN;
        end else begin
            avg = SW'(128);
        end
        dc_o = avg[7:0];
    end

endmodule

// File: rtl/ipg_row_unit.sv
module ipg_row_unit
    import ipg_pkg::*;
#(
    parameter int N  = 16,
    parameter int RW = 4
) (
    input  ipg_mode_e      mode_i,
    input  logic [RW-1:0]  row_i,
    input  logic [N*8-1:0] above_i,
    input  logic [N*8-1:0] left_i,
    input  logic [7:0]     corner_i,
    input  logic [7:0]     dc_i,
    output logic [N*8-1:0] pix_o
);
    logic [7:0] lpix;

    // gradient on a signed 10-bit intermediate, then saturate
    function automatic logic [7:0] tm_clip(input logic [7:0] l,
                                           input logic [7:0] a,
                                           input logic [7:0] t);
        logic signed [9:0] v;
        v = $signed({2'b00, l}) + $signed({2'b00, a}) - $signed({2'b00, t});
        if (v < 0)             return 8'd0;
        else if (v > 10'sd255) return 8'd255;
        else                   return v[7:0];
    endfunction

    always_comb begin
        lpix = left_i[{row_i, 3'b000} +: 8];
        for (int c = 0; c < N; c++) begin
            case (mode_i)
                IPG_VERT: pix_o[c*8 +: 8] = above_i[c*8 +: 8];
                IPG_HORZ: pix_o[c*8 +: 8] = lpix;
                IPG_TM:   pix_o[c*8 +: 8] = tm_clip(lpix, above_i[c*8 +: 8], corner_i);
                default:  pix_o[c*8 +: 8] = dc_i;
            endcase
        end
    end

endmodule

// File: rtl/intra_pred_gen.sv
module intra_pred_gen
    import ipg_pkg::*;
#(
    parameter int N      = 16,
    parameter int PLANES = 1
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   start_i,
    input  logic [2:0]             mode_i,
    input  logic                   up_avail_i,
    input  logic                   left_avail_i,
    input  logic [PLANES*N*8-1:0]  above_i,
    input  logic [PLANES*8-1:0]    corner_i,
    input  logic [PLANES*N*8-1:0]  left_i,
    output logic [PLANES*N*8-1:0]  pix_o,
    output logic [$clog2(N)-1:0]   row_o,
    output logic                   valid_o,
    output logic                   done_o
);
    localparam int RW = $clog2(N);
    localparam int PW = PLANES * N * 8;
    localparam int CW = PLANES * 8;
    localparam logic [RW-1:0] LAST_ROW = RW'(N - 1);

    typedef struct packed {
        ipg_phase_e    phase;
        logic [RW-1:0] row;
        ipg_mode_e     mode;
        logic          up;
        logic          lf;
        logic [PW-1:0] above;
        logic [PW-1:0] left;
        logic [CW-1:0] corner;
        logic [CW-1:0] dc;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] dc_w;
    logic [PW-1:0] pix_w;
    logic          mode_ok;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        ipg_dc_unit #(.N(N)) u_dc (
            .above_i (st_q.above[p*N*8 +: N*8]),
            .left_i  (st_q.left[p*N*8 +: N*8]),
            .up_i    (st_q.up),
            .lf_i    (st_q.lf),
            .dc_o    (dc_w[p*8 +: 8])
        );
        ipg_row_unit #(.N(N), .RW(RW)) u_row (
            .mode_i   (st_q.mode),
            .row_i    (st_q.row),
            .above_i  (st_q.above[p*N*8 +: N*8]),
            .left_i   (st_q.left[p*N*8 +: N*8]),
            .corner_i (st_q.corner[p*8 +: 8]),
            .dc_i     (st_q.dc[p*8 +: 8]),
            .pix_o    (pix_w[p*N*8 +: N*8])
        );
    end

    assign mode_ok = (mode_i < 3'd4);

    always_comb begin
        st_d = st_q;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i && mode_ok) begin
                    st_d.phase  = PH_SETUP;
                    st_d.row    = '0;
                    st_d.mode   = ipg_mode_e'(mode_i);
                    st_d.up     = up_avail_i;
                    st_d.lf     = left_avail_i;
                    st_d.above  = above_i;
                    st_d.left   = left_i;
                    st_d.corner = corner_i;
                end
            end
            PH_SETUP: begin
                st_d.dc    = dc_w;
                st_d.phase = PH_RUN;
            end
            PH_RUN: begin
                if (st_q.row == LAST_ROW) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.row = st_q.row + RW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = (st_q.phase == PH_RUN);
    assign row_o   = st_q.row;
    assign done_o  = valid_o && (st_q.row == LAST_ROW);
    assign pix_o   = valid_o ? pix_w : '0;

    // R9: rows advance by one each cycle until the last
    a_r9_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && row_o != LAST_ROW) |=> (valid_o && row_o == $past(row_o) + RW'(1)));

    // R9: setup cycle is followed by row 0
    a_r9_setup_then_row0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_SETUP) |=> (valid_o && row_o == '0));

    // R10: stream ends right after done
    a_r10_done_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !valid_o);

    // R8: illegal mode codes never leave idle
    a_r8_bad_mode_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_IDLE && start_i && mode_i[2]) |=> (st_q.phase == PH_IDLE));

    // R11 / R12: captured state stays fixed while busy
    a_r11_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_RUN) |=> ($stable(st_q.mode) && $stable(st_q.above)
                                    && $stable(st_q.left) && $stable(st_q.corner)));

    // R1: vertical rows reproduce the captured above row
    a_r1_vert_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && st_q.mode == IPG_VERT) |-> (pix_o == st_q.above));

    // R6: no neighbours gives mid-grey
    a_r6_dc_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && st_q.mode == IPG_DC && !st_q.up && !st_q.lf)
            |-> (pix_o == {(PLANES*N){8'd128}}));

endmodule

// File: tb/intra_pred_gen_tb_top.sv
module intra_pred_gen_tb_top;
    localparam int N  = 8;
    localparam int NP = 2;
    localparam int PW = NP * N * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [2:0]      mode = 3'd0;
    logic            upv = 1'b0;
    logic            lfv = 1'b0;
    logic [PW-1:0]   above = '0;
    logic [NP*8-1:0] corner = '0;
    logic [PW-1:0]   left = '0;
    logic [PW-1:0]   pix;
    logic [2:0]      row;
    logic            valid;
    logic            done;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    logic [7:0] ab [NP][N];
    logic [7:0] lf [NP][N];
    logic [7:0] tl [NP];

    always #2 clk = ~clk;

    intra_pred_gen #(.N(N), .PLANES(NP)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
        .up_avail_i(upv), .left_avail_i(lfv), .above_i(above),
        .corner_i(corner), .left_i(left), .pix_o(pix), .row_o(row),
        .valid_o(valid), .done_o(done)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    function automatic logic [7:0] expv(int m, bit u, bit l, int p, int r, int c);
        int sa = 0, sl = 0, t;
        for (int k = 0; k < N; k++) begin
            sa += ab[p][k];
            sl += lf[p][k];
        end
        case (m)
            1: return ab[p][c];
            2: return lf[p][r];
            3: begin
                t = lf[p][r] + ab[p][c] - tl[p];
                if (t < 0) t = 0;
                if (t > 255) t = 255;
                return 8'(t);
            end
            default: begin
                if (u && l)  return 8'((sa + sl + 8) >> 4);
                else if (u)  return 8'((sa + 4) >> 3);
                else if (l)  return 8'((sl + 4) >> 3);
                else         return 8'd128;
            end
        endcase
    endfunction

    function automatic string tag(int m, bit u, bit l, int p);
        string s;
        case (m)
            1: s = "R1";
            2: s = "R2";
            3: s = "R3";
            default: s = (u && l) ? "R4" : ((u || l) ? "R5" : "R6");
        endcase
        if (p == 1) s = {s, " R7 plane1"};
        return {s, " R12 held inputs"};
    endfunction

    // pattern 0/4 random, 1 saturate high, 2 saturate low, 3 ramps
    task automatic fill(input int pat);
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < N; k++) begin
                case (pat)
                    1: begin ab[p][k] = 8'd250 - 8'(k); lf[p][k] = 8'd255; end
                    2: begin ab[p][k] = 8'(k); lf[p][k] = 8'd3; end
                    3: begin ab[p][k] = 8'(k * 31 + p * 7); lf[p][k] = 8'(200 - k * 17 - p); end
                    default: begin ab[p][k] = 8'($urandom); lf[p][k] = 8'($urandom); end
                endcase
            end
            case (pat)
                1: tl[p] = 8'(p * 2);
                2: tl[p] = 8'd255 - 8'(p);
                default: tl[p] = 8'($urandom);
            endcase
        end
    endtask

    task automatic drive_ports();
        for (int p = 0; p < NP; p++) begin
            corner[p*8 +: 8] = tl[p];
            for (int k = 0; k < N; k++) begin
                above[(p*N+k)*8 +: 8] = ab[p][k];
                left[(p*N+k)*8 +: 8]  = lf[p][k];
            end
        end
    endtask

    task automatic run_case(input int m, input bit u, input bit l, input int pat);
        logic [63:0] e, g;
        fill(pat);
        @(negedge clk);
        drive_ports();
        mode = 3'(m); upv = u; lfv = l; start = 1'b1;
        @(negedge clk);
        // R12: scramble every input after capture; R11: conflicting start while busy
        above = {$urandom, $urandom, $urandom, $urandom};
        left  = {$urandom, $urandom, $urandom, $urandom};
        corner = 16'($urandom);
        mode = 3'((m + 1) % 4); upv = ~u; lfv = ~l; start = 1'b1;
        chk(!valid, "R9 setup cycle valid low", 64'(valid), 64'd0);
        for (int r = 0; r < N; r++) begin
            @(negedge clk);
            start = 1'b0;
            chk(valid && row == 3'(r), "R9 R11 row sequence", {62'd0, valid, 1'b0} | 64'(row),
                {62'd0, 1'b1, 1'b0} | 64'(r));
            chk(done == (r == N - 1), "R10 done on last row", 64'(done), 64'(r == N - 1));
            for (int p = 0; p < NP; p++) begin
                for (int c = 0; c < N; c++) e[c*8 +: 8] = expv(m, u, l, p, r, c);
                g = pix[p*N*8 +: N*8];
                chk(g == e, tag(m, u, l, p), g, e);
            end
        end
        @(negedge clk);
        chk(!valid && !done, "R10 valid drops after last row", {63'd0, valid}, 64'd0);
    endtask

    task automatic run_bad(input int m);
        @(negedge clk);
        mode = 3'(m); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < N + 2; k++) begin
            chk(!valid && !done, "R8 illegal mode produces nothing", {62'd0, valid, done}, 64'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!valid && !done && pix == '0, "R9 reset state", {62'd0, valid, done}, 64'd0);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 4; a++)
                for (int pat = 0; pat < 5; pat++)
                    run_case(m, a[1], a[0], pat);
        for (int m = 4; m < 8; m++) run_bad(m);
        // back-to-back after an illegal code still works
        run_case(3, 1'b1, 1'b1, 1);
        summary();
    end

endmodule